// File: doc/BRIEF.md
# Conditional Execution Flag Gate

This block sits at the issue stage of a pipelined integer core. It holds the four architectural status flags: negative, zero, carry and overflow. Each cycle it decides whether the instruction being issued may commit. The instruction supplies a 4-bit condition code and a valid strobe. The gate checks the code against the flags as they stand in that cycle. In the same cycle it raises either a commit or a squash indication.

A squashed instruction still takes its issue slot, so the pipeline never has to refill. Squashing an instruction also blocks its update to the flags. The flags take new values from the ALU at a clock edge only when an instruction commits and asks to set flags. Otherwise they hold.

Top module: `pred_gate`

## Requirements
- R1: A synchronous active-high reset clears all four flags, so `flags_q` reads 4'b0000 at the first edge after reset is sampled.
- R2: Code 4'b0000 passes when Z=1. Code 4'b0001 passes when Z=0.
- R3: Code 4'b0010 passes when C=1. Code 4'b0011 passes when C=0.
- R4: Code 4'b0100 passes when N=1 and code 4'b0101 passes when N=0. Code 4'b0110 passes when V=1 and code 4'b0111 passes when V=0.
- R5: Code 4'b1000 passes when C=1 and Z=0. Code 4'b1001 passes when C=0 or Z=1.
- R6: The signed comparison codes are evaluated as follows:
  - 4'b1010 passes when N equals V.
  - 4'b1011 passes when N differs from V.
  - 4'b1100 passes when Z=0 and N equals V.
  - 4'b1101 passes when Z=1 or N differs from V.
- R7: Code 4'b1110 always passes. Code 4'b1111 never passes.
- R8: Commit and squash depend only on inputs and flags within the same cycle, with no cycle of delay. With `iss_vld` high, exactly one of them is high. With `iss_vld` low, both are low.
- R9: The flags take `alu_flags` at a clock edge when `iss_vld`, `iss_setf` and pass are all high. Both flag vectors use the bit order {N,Z,C,V}, bits 3 down to 0.
- R10: The flags keep their value across an edge in three cases: the instruction is squashed, `iss_setf` is low, or `iss_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | An instruction is issued this cycle |
| iss_cond | input | 4 | Condition code of the issued instruction |
| iss_setf | input | 1 | The instruction requests a flag update |
| alu_flags | input | 4 | New {N,Z,C,V} from the ALU |
| commit | output | 1 | Issued instruction executes |
| squash | output | 1 | Issued instruction is discarded |
| flags_q | output | 4 | Current {N,Z,C,V} |

## Verification
The assertions assume that `iss_cond`, `iss_setf` and `alu_flags` are settled before each rising edge. They do not assume that `iss_setf` or `alu_flags` are meaningful while `iss_vld` is low. The stimulus changes inputs only on the falling edge. It then runs all 16 codes against all 16 flag values, with each flag value loaded through a committed always-pass instruction. It also drives a flag update with `iss_setf` high while `iss_vld` is low, and a failing code with `iss_setf` high. In both cases it presents the complement of the held flags, so any leak into the flags shows up at `flags_q`.

// File: rtl/pred_gate_pkg.sv
package pred_gate_pkg;

    localparam int COND_W = 4;
    localparam int FLAG_W = 4;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // Pair selector: upper three bits of the condition code.
    // The low bit inverts the sense of the pair.
    typedef enum logic [2:0] {
        PAIR_ZERO  = 3'd0,
        PAIR_CARRY = 3'd1,
        PAIR_NEG   = 3'd2,
        PAIR_OVF   = 3'd3,
        PAIR_UHI   = 3'd4,
        PAIR_SGE   = 3'd5,
        PAIR_SGT   = 3'd6,
        PAIR_ALWAYS= 3'd7
    } cond_pair_e;

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import pred_gate_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  flags_t            flags,
    output logic              pass
);

    cond_pair_e pair;
    logic       base;

    assign pair = cond_pair_e'(cond[COND_W-1:1]);

    always_comb begin
        unique case (pair)
            PAIR_ZERO:   base = flags.z;
            PAIR_CARRY:  base = flags.c;
            PAIR_NEG:    base = flags.n;
            PAIR_OVF:    base = flags.v;
            PAIR_UHI:    base = flags.c & ~flags.z;
            PAIR_SGE:    base = ~(flags.n ^ flags.v);
            PAIR_SGT:    base = ~flags.z & ~(flags.n ^ flags.v);
            PAIR_ALWAYS: base = 1'b1;
        endcase
    end

    // Odd codes take the complement of their even partner.
    // For the last pair this gives always, then never.
    assign pass = cond[0] ? ~base : base;

endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import pred_gate_pkg::*;
#(
    parameter logic [FLAG_W-1:0] RST_VAL = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  flags_t d,
    output flags_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= flags_t'(RST_VAL);
        else if (wr_en)
            q <= d;
    end

endmodule

// File: rtl/pred_gate.sv
module pred_gate
    import pred_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_vld,
    input  logic [COND_W-1:0] iss_cond,
    input  logic              iss_setf,
    input  logic [FLAG_W-1:0] alu_flags,
    output logic              commit,
    output logic              squash,
    output logic [FLAG_W-1:0] flags_q
);

    flags_t cur_flags;
    logic   pass;
    logic   upd;

    cond_eval u_eval (
        .cond  (iss_cond),
        .flags (cur_flags),
        .pass  (pass)
    );

    assign commit = iss_vld & pass;
    assign squash = iss_vld & ~pass;
    assign upd    = commit & iss_setf;

    flag_reg #(.RST_VAL('0)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .wr_en (upd),
        .d     (flags_t'(alu_flags)),
        .q     (cur_flags)
    );

    assign flags_q = cur_flags;

    // R1
    flags_cleared_chk: assert property (@(posedge clk)
        rst |=> flags_q == '0);

    // R8
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        iss_vld |-> $countones({commit, squash}) == 1);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !iss_vld |-> !commit && !squash);

    // R7
    never_code_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_vld && iss_cond == 4'hF) |-> squash);

    // R7
    always_code_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_vld && iss_cond == 4'hE) |-> commit);

    // R9
    flag_load_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && iss_setf) |=> flags_q == $past(alu_flags));

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(commit && iss_setf) |=> $stable(flags_q));

endmodule

// File: tb/pred_gate_tb.sv
module pred_gate_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       iss_vld;
    logic [3:0] iss_cond;
    logic       iss_setf;
    logic [3:0] alu_flags;
    logic       commit;
    logic       squash;
    logic [3:0] flags_q;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pred_gate u_dut (
        .clk       (clk),
        .rst       (rst),
        .iss_vld   (iss_vld),
        .iss_cond  (iss_cond),
        .iss_setf  (iss_setf),
        .alu_flags (alu_flags),
        .commit    (commit),
        .squash    (squash),
        .flags_q   (flags_q)
    );

    // Expected outcome per code, written from the requirement list; f = {N,Z,C,V}
    function automatic logic want_pass(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:  return z;                    // R2
            4'd1:  return !z;                   // R2
            4'd2:  return cy;                   // R3
            4'd3:  return !cy;                  // R3
            4'd4:  return n;                    // R4
            4'd5:  return !n;                   // R4
            4'd6:  return v;                    // R4
            4'd7:  return !v;                   // R4
            4'd8:  return cy && !z;             // R5
            4'd9:  return !cy || z;             // R5
            4'd10: return n == v;               // R6
            4'd11: return n != v;               // R6
            4'd12: return !z && (n == v);       // R6
            4'd13: return z || (n != v);        // R6
            4'd14: return 1'b1;                 // R7
            default: return 1'b0;               // R7
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd0, 4'd1:              return "R2";
            4'd2, 4'd3:              return "R3";
            4'd4, 4'd5, 4'd6, 4'd7:  return "R4";
            4'd8, 4'd9:              return "R5";
            4'd14, 4'd15:            return "R7";
            default:                 return "R6";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] c,
                         input logic s, input logic [3:0] a);
        iss_vld = v; iss_cond = c; iss_setf = s; alu_flags = a;
    endtask

    task automatic t_reset();
        @(negedge clk);
        drive(1'b1, 4'hE, 1'b1, 4'hF);
        @(negedge clk);
        check("R9", "preload", flags_q, 4'hF);
        rst = 1'b1;
        drive(1'b0, 4'h0, 1'b0, 4'h0);
        @(negedge clk);
        rst = 1'b0;
        check("R1", "flags after reset", flags_q, 4'h0);
    endtask

    task automatic t_load(input logic [3:0] f);
        @(negedge clk);
        drive(1'b1, 4'hE, 1'b1, f);
        #1 check("R8", "commit on load", {3'b0, commit}, 4'd1);
        @(negedge clk);
        check("R9", "flag load", flags_q, f);
    endtask

    task automatic t_sweep(input logic [3:0] f);
        for (int c = 0; c < 16; c++) begin
            drive(1'b1, 4'(c), 1'b0, ~f);
            #1;
            check(req_of(4'(c)), $sformatf("code %0d flags %b", c, f),
                  {2'b0, commit, squash},
                  {2'b0, want_pass(4'(c), f), !want_pass(4'(c), f)});
            @(negedge clk);
            check("R10", "setf low hold", flags_q, f);
        end
    endtask

    task automatic t_squash_hold(input logic [3:0] f);
        @(negedge clk);
        drive(1'b1, 4'hF, 1'b1, ~f);
        #1 check("R8", "squash raised", {3'b0, squash}, 4'd1);
        @(negedge clk);
        check("R10", "squash keeps flags", flags_q, f);
    endtask

    task automatic t_idle_hold(input logic [3:0] f);
        @(negedge clk);
        drive(1'b0, 4'hE, 1'b1, ~f);
        #1 check("R8", "idle outputs low", {2'b0, commit, squash}, 4'd0);
        @(negedge clk);
        check("R10", "invalid keeps flags", flags_q, f);
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b0, 4'h0, 1'b0, 4'h0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1", "flags at reset", flags_q, 4'h0);
        t_reset();
        for (int f = 0; f < 16; f++) begin
            t_load(4'(f));
            t_sweep(4'(f));
            t_squash_hold(4'(f));
            t_idle_hold(4'(f));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule